// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block keeps the modem-status byte of a serial port. Its upper nibble shows four modem line levels as active-high values, taken from the active-low clear-to-send, data-set-ready, ring and carrier-detect pins. Its lower nibble holds four sticky change flags that the host reads to learn which lines moved since the last read.

The pins are asynchronous to the block clock, so each one passes through a two-flop synchronizer before use. A loop-enable input turns on a diagnostic loopback mode. In that mode the upper nibble is taken from the port's own modem-control outputs rather than from the pins. The change flags follow whichever source is selected, so switching modes can itself raise flags. A host read strobe returns the byte and clears the flags.

Top module: `modem_status_reg`

## Requirements
- R1: While reset is asserted and on the first cycle after it, rd_data is 8'h00.
- R2: With loop_en low, bits 4, 5, 6 and 7 of rd_data equal the inverse of cts_n, dsr_n, ri_n and dcd_n respectively, three clock edges after the pin changes (two synchronizer flops plus the status register).
- R3: With loop_en high, bit 4 follows ctl_rts, bit 5 follows ctl_dtr, bit 6 follows ctl_out1 and bit 7 follows ctl_out2, one clock edge after the input changes.
- R4: Bits 0, 1 and 3 are flags that set on the edge where bit 4, bit 5 or bit 7 respectively changes value, in either direction.
- R5: Bit 2 sets only on the edge where bit 6 goes from 1 to 0. A 0-to-1 change of bit 6 leaves it unchanged.
- R6: Once set, a flag in bits 3:0 stays set until a read clears it.
- R7: A clock edge with rd_stb high clears bits 3:0. A change occurring on that same edge still sets its flag.
- R8: With loop_en high, activity on the four modem pins has no effect on rd_data.
- R9: Toggling loop_en changes the source of bits 7:4. Any bit whose value differs between the old and new source sets its flag under the rules of R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect pin, active low, asynchronous |
| ctl_dtr | input | 1 | Modem-control DTR bit, the source of bit 5 in loopback |
| ctl_rts | input | 1 | Modem-control RTS bit, the source of bit 4 in loopback |
| ctl_out1 | input | 1 | Modem-control auxiliary output 1, the source of bit 6 in loopback |
| ctl_out2 | input | 1 | Modem-control auxiliary output 2, the source of bit 7 in loopback |
| loop_en | input | 1 | Loopback mode enable |
| rd_stb | input | 1 | Host read strobe; clears the flags on this edge |
| rd_data | output | 8 | Status byte: {levels[3:0], flags[3:0]} |

## Verification
The hardest case to reach is a line change and a host read landing on the same clock edge. For a pin, the read must be timed to the third edge after the pin moves, past the synchronizer delay. A directed step lowers dsr_n and raises rd_stb exactly two edges later. The random phase then hits this edge many more times by drawing reads with high probability while the pins and control bits churn. Loop-mode switches, in which the source changes under stable flags, are driven both directly and at random.

// File: rtl/modem_status_reg.sv
module modem_status_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       ctl_dtr,
  input  logic       ctl_rts,
  input  logic       ctl_out1,
  input  logic       ctl_out2,
  input  logic       loop_en,
  input  logic       rd_stb,
  output logic [7:0] rd_data
);

  logic [SYNC_STAGES-1:0][3:0] sync_q;
  logic [3:0] lvl_q, delta_q, src, chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= ~{dcd_n, ri_n, dsr_n, cts_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign src = loop_en ? {ctl_out2, ctl_out1, ctl_dtr, ctl_rts} : sync_q[SYNC_STAGES-1];

  assign chg = {src[3] ^ lvl_q[3],
                lvl_q[2] & ~src[2],
                src[1] ^ lvl_q[1],
                src[0] ^ lvl_q[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      delta_q <= '0;
    end else begin
      lvl_q   <= src;
      delta_q <= (rd_stb ? 4'h0 : delta_q) | chg;
    end
  end

  assign rd_data = {lvl_q, delta_q};

endmodule

module modem_status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_dtr,
  input logic       ctl_rts,
  input logic       ctl_out1,
  input logic       ctl_out2,
  input logic       loop_en,
  input logic       rd_stb,
  input logic [7:0] rd_data
);

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  always_ff @(posedge clk) if (!rst_n) AST_RESET_CLEAR: assert (rd_data == 8'h00); // R1

  AST_LOOP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(loop_en) |-> rd_data[7:4] == $past({ctl_out2, ctl_out1, ctl_dtr, ctl_rts})); // R3

  AST_DELTA_CTS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && rd_data[4] != $past(rd_data[4]) |-> rd_data[0]); // R4

  AST_DELTA_DSR: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && rd_data[5] != $past(rd_data[5]) |-> rd_data[1]); // R4

  AST_DELTA_DCD: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && rd_data[7] != $past(rd_data[7]) |-> rd_data[3]); // R4

  AST_RING_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(rd_data[6]) && !rd_data[6] |-> rd_data[2]); // R5

  AST_RING_NO_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(rd_stb) && !($past(rd_data[6]) && !rd_data[6]) |-> !rd_data[2]); // R5

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(rd_stb) |-> (rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])); // R6

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(rd_stb) && rd_data[7:4] == $past(rd_data[7:4]) |-> rd_data[3:0] == 4'h0); // R7

endmodule

bind modem_status_reg modem_status_reg_chk u_chk (.*);

// File: tb/test_modem_status_reg.sv
`timescale 1ns/1ps
module test_modem_status_reg;
  logic clk = 0, rst_n = 0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic ctl_dtr = 0, ctl_rts = 0, ctl_out1 = 0, ctl_out2 = 0;
  logic loop_en = 0, rd_stb = 0;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  modem_status_reg i_modem_status_reg (.*);

  // expected-value model derived from R2..R9
  logic [3:0] m_p1, m_p2, m_up, m_fl;
  function automatic logic [3:0] pick_src(logic lp, logic [3:0] pins_sync);
    return lp ? {ctl_out2, ctl_out1, ctl_dtr, ctl_rts} : pins_sync;
  endfunction
  function automatic logic [3:0] new_flags(logic [3:0] old_lvl, logic [3:0] new_lvl);
    logic [3:0] f;
    f[0] = old_lvl[0] != new_lvl[0];
    f[1] = old_lvl[1] != new_lvl[1];
    f[2] = old_lvl[2] && !new_lvl[2];
    f[3] = old_lvl[3] != new_lvl[3];
    return f;
  endfunction
  always @(posedge clk) begin
    if (!rst_n) begin
      m_p1 <= 0; m_p2 <= 0; m_up <= 0; m_fl <= 0;
    end else begin
      m_p1 <= ~{dcd_n, ri_n, dsr_n, cts_n};
      m_p2 <= m_p1;
      m_up <= pick_src(loop_en, m_p2);
      m_fl <= (rd_stb ? 4'h0 : m_fl) | new_flags(m_up, pick_src(loop_en, m_p2));
    end
  end

  task automatic check(string tag, logic [7:0] exp);
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: rd_data got %h expected %h at %0t", tag, rd_data, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_read();
    rd_stb = 1; tick(); rd_stb = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(2);
    check("R1 in reset", 8'h00);
    rst_n = 1; tick();
    check("R1 after reset", 8'h00);

    cts_n = 0; tick(2);
    check("R2 sync latency", 8'h00);
    tick();
    check("R2/R4 cts asserted", 8'h11);
    tick(3);
    check("R6 flag held", 8'h11);
    do_read();
    check("R7 read clears", 8'h10);

    ri_n = 0; tick(3);
    check("R5 ring leading edge ignored", 8'h50);
    ri_n = 1; tick(3);
    check("R5 ring trailing edge", 8'h14);
    do_read();
    check("R7 clear after ring", 8'h10);

    dsr_n = 0; tick(2);
    rd_stb = 1; tick(); rd_stb = 0;
    check("R7 change with read", 8'h32);
    do_read();
    check("R7 clear", 8'h30);

    loop_en = 1; tick();
    check("R9 enter loop", 8'h03);
    do_read();
    check("R7 clear in loop", 8'h00);
    ctl_rts = 1; tick();
    check("R3 rts to bit4", 8'h11);
    ctl_dtr = 1; ctl_out1 = 1; ctl_out2 = 1; tick();
    check("R3/R5 all control bits", 8'hFB);
    do_read();
    check("R7 clear loop", 8'hF0);

    for (int i = 0; i < 6; i++) begin
      {dcd_n, ri_n, dsr_n, cts_n} = 4'(i * 5 + 3);
      tick();
      check("R8 pins ignored in loop", 8'hF0);
    end
    {dcd_n, ri_n, dsr_n, cts_n} = 4'hF; tick(3);
    check("R8 pins ignored settle", 8'hF0);
    loop_en = 0; tick();
    check("R9 leave loop", 8'h0F);
    do_read();
    check("R7 clear final", 8'h00);

    for (int i = 0; i < 4000; i++) begin
      if (rd_data[7:4] != m_up || rd_data[3:0] != m_fl) begin
        checks++; fails++;
        $display("FAIL %s: rd_data got %h expected %h at %0t",
                 rd_data[7:4] != m_up ? (loop_en ? "R3" : "R2") : "R4/R5/R6/R7",
                 rd_data, {m_up, m_fl}, $time);
      end else checks++;
      if ($urandom_range(0, 3) == 0) {dcd_n, ri_n, dsr_n, cts_n} = 4'($urandom);
      if ($urandom_range(0, 3) == 0) {ctl_out2, ctl_out1, ctl_dtr, ctl_rts} = 4'($urandom);
      if ($urandom_range(0, 19) == 0) loop_en = ~loop_en;
      rd_stb = ($urandom_range(0, 2) == 0);
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule